// File: doc/BRIEF.md
# System-to-Peripheral Bus Bridge

This block sits between a pipelined high-speed system bus and a simple low-power peripheral bus. It is a slave on the system side and the only master on the peripheral side. Both sides run on one clock. A transfer is accepted in a single address cycle. The bridge latches the address and direction of that transfer. It decodes a field of the latched address into one select line per peripheral. It then runs a two-step access on the peripheral side: a setup cycle, followed by an enable cycle.

The system-side data phase is stretched by one wait state. This gives the peripheral the full two-step access. Write data arrives in the cycle after the address phase and is forwarded. Read data from the selected peripheral is returned during the enable cycle.

A new address phase may be presented in the enable cycle. The bridge then goes directly into the next setup. When the bus goes quiet, the peripheral address, direction and write data keep their last values, so those lines do not toggle.

Top module: `pbus_bridge`

## Requirements
- R1: After reset, sys_ready_o is 1, per_sel_o is 0, per_enable_o is 0, and per_addr_o, per_write_o and per_wdata_o are 0.
- R2: A transfer is accepted when sys_sel_i, sys_valid_i and sys_ready_o are all 1 at a clock edge. The following cycle is a setup cycle: the decoded select is high, per_enable_o is low and sys_ready_o is low.
- R3: The cycle after a setup cycle is always an enable cycle. In it the select stays high, per_enable_o is 1 and sys_ready_o is 1. per_enable_o is never high in two cycles in a row.
- R4: per_addr_o and per_write_o show the address and direction captured at acceptance. They do not change from the setup cycle through the enable cycle.
- R5: The region field is sys_addr bits [15:12] (AW=16, REGION_LSB=12). Field value k < 4 raises only per_sel_o[k]. A field value of 4 or more raises no select, but the setup/enable timing is unchanged.
- R6: In the setup cycle of a write, per_wdata_o equals sys_wdata_i. The bridge captures that value at the end of setup and drives it in the enable cycle.
- R7: In the enable cycle of a read to a mapped region, sys_rdata_o equals bits [32k+31:32k] of per_rdata_i for region k. In every other cycle sys_rdata_o is 0, and this includes reads to unmapped regions.
- R8: A transfer accepted in an enable cycle is followed directly by its setup cycle, with no idle cycle between them.
- R9: When no transfer is accepted (sys_sel_i or sys_valid_i low), the bridge stays idle with select and enable low. per_addr_o, per_write_o and per_wdata_o keep their last values.
- R10: sys_ready_o is low only in setup cycles, and only for one cycle per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_sel_i | input | 1 | Bridge selected on the system bus |
| sys_valid_i | input | 1 | Address phase carries a real transfer |
| sys_addr_i | input | AW | System address |
| sys_write_i | input | 1 | 1 = write, 0 = read |
| sys_wdata_i | input | DW | Write data, valid in the data phase |
| sys_ready_o | output | 1 | Data phase completes when high |
| sys_rdata_o | output | DW | Read data to the system bus |
| per_addr_o | output | AW | Latched peripheral address |
| per_write_o | output | 1 | Latched direction |
| per_sel_o | output | N_PERIPH | One-hot peripheral select |
| per_enable_o | output | 1 | Enable strobe |
| per_wdata_o | output | DW | Write data to peripherals |
| per_rdata_i | input | N_PERIPH*DW | Read data, one slot per peripheral |

## Verification
An accepted address phase produces the setup cycle one clock edge later: select high and ready low. The enable cycle, with read data on sys_rdata_o, follows one edge after that. Write data taken in setup shows up on per_wdata_o in the same setup cycle and stays there through enable. The reference model in the bench moves its phase counter at each rising edge, using only the inputs it drove. The bench compares every output on the falling edge and changes inputs just after it, so each result is read in the cycle in which it is due. A seeded random phase mixes back-to-back, unmapped, read and write transfers, and idle cycles in which one of the two qualifiers is low.

// File: rtl/pbus_bridge_pkg.sv
package pbus_bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ENABLE = 2'd2
  } pbus_state_e;
endpackage

// File: rtl/pbus_bridge_fsm.sv
module pbus_bridge_fsm
  import pbus_bridge_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  output pbus_state_e state_o
);
  pbus_state_e state_d, state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   state_d = start_i ? ST_SETUP : ST_IDLE;
      ST_SETUP:  state_d = ST_ENABLE;
      ST_ENABLE: state_d = start_i ? ST_SETUP : ST_IDLE; // back-to-back skips idle
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/pbus_bridge_latch.sv
module pbus_bridge_latch #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic          write_i,
  input  logic          wcap_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] addr_o,
  output logic          write_o,
  output logic [DW-1:0] wdata_o
);
  // Registers load only on a new transfer, so idle lines stay quiet.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      write_o <= 1'b0;
    end else if (load_i) begin
      addr_o  <= addr_i;
      write_o <= write_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wdata_o <= '0;
    else if (wcap_i) wdata_o <= wdata_i;
  end
endmodule

// File: rtl/pbus_bridge_decode.sv
module pbus_bridge_decode #(
  parameter int unsigned AW         = 16,
  parameter int unsigned REGION_LSB = 12,
  parameter int unsigned N_PERIPH   = 4
) (
  input  logic [AW-1:0]       addr_i,
  output logic [N_PERIPH-1:0] sel_o
);
  localparam int unsigned FW = AW - REGION_LSB;

  logic [FW-1:0] field;
  assign field = addr_i[AW-1:REGION_LSB];

  for (genvar k = 0; k < N_PERIPH; k++) begin : g_sel
    assign sel_o[k] = (field == FW'(k));
  end
endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
  import pbus_bridge_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned DW         = 32,
  parameter int unsigned REGION_LSB = 12,
  parameter int unsigned N_PERIPH   = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sys_sel_i,
  input  logic                   sys_valid_i,
  input  logic [AW-1:0]          sys_addr_i,
  input  logic                   sys_write_i,
  input  logic [DW-1:0]          sys_wdata_i,
  output logic                   sys_ready_o,
  output logic [DW-1:0]          sys_rdata_o,
  output logic [AW-1:0]          per_addr_o,
  output logic                   per_write_o,
  output logic [N_PERIPH-1:0]    per_sel_o,
  output logic                   per_enable_o,
  output logic [DW-1:0]          per_wdata_o,
  input  logic [N_PERIPH*DW-1:0] per_rdata_i
);
  pbus_state_e         state;
  logic                accept, in_setup, in_enable, wcap;
  logic [DW-1:0]       wdata_q;
  logic [N_PERIPH-1:0] dec_sel;

  assign in_setup    = (state == ST_SETUP);
  assign in_enable   = (state == ST_ENABLE);
  assign sys_ready_o = !in_setup;
  assign accept      = sys_sel_i && sys_valid_i && sys_ready_o;
  assign wcap        = in_setup && per_write_o;

  pbus_bridge_fsm i_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .state_o (state)
  );

  pbus_bridge_latch #(.AW(AW), .DW(DW)) i_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .addr_i  (sys_addr_i),
    .write_i (sys_write_i),
    .wcap_i  (wcap),
    .wdata_i (sys_wdata_i),
    .addr_o  (per_addr_o),
    .write_o (per_write_o),
    .wdata_o (wdata_q)
  );

  pbus_bridge_decode #(.AW(AW), .REGION_LSB(REGION_LSB), .N_PERIPH(N_PERIPH)) i_dec (
    .addr_i (per_addr_o),
    .sel_o  (dec_sel)
  );

  assign per_sel_o    = (in_setup || in_enable) ? dec_sel : '0;
  assign per_enable_o = in_enable;
  // Setup forwards the data phase directly; enable uses the captured copy.
  assign per_wdata_o  = wcap ? sys_wdata_i : wdata_q;

  always_comb begin
    sys_rdata_o = '0;
    if (in_enable && !per_write_o) begin
      for (int k = 0; k < int'(N_PERIPH); k++) begin
        if (dec_sel[k]) sys_rdata_o = per_rdata_i[k*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/pbus_bridge_chk.sv
module pbus_bridge_chk #(
  parameter int unsigned AW       = 16,
  parameter int unsigned N_PERIPH = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sys_sel_i,
  input logic                sys_valid_i,
  input logic                sys_ready_o,
  input logic [AW-1:0]       per_addr_o,
  input logic                per_write_o,
  input logic [N_PERIPH-1:0] per_sel_o,
  input logic                per_enable_o
);
  // R5
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(per_sel_o));

  // R2
  accept_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_sel_i && sys_valid_i && sys_ready_o) |=> (!sys_ready_o && !per_enable_o));

  // R3
  setup_then_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_ready_o |=> (per_enable_o && sys_ready_o));

  // R3
  enable_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_enable_o |=> !per_enable_o);

  // R4
  hold_in_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_enable_o |-> ($stable(per_addr_o) && $stable(per_write_o) && $stable(per_sel_o)));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_ready_o && !(sys_sel_i && sys_valid_i)) |=>
      ($stable(per_addr_o) && $stable(per_write_o) && !per_enable_o && per_sel_o == '0));

  // R10
  ready_low_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_ready_o |=> sys_ready_o);
endmodule

bind pbus_bridge pbus_bridge_chk #(.AW(AW), .N_PERIPH(N_PERIPH)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sys_sel_i    (sys_sel_i),
  .sys_valid_i  (sys_valid_i),
  .sys_ready_o  (sys_ready_o),
  .per_addr_o   (per_addr_o),
  .per_write_o  (per_write_o),
  .per_sel_o    (per_sel_o),
  .per_enable_o (per_enable_o)
);

// File: tb/test_pbus_bridge.sv
module test_pbus_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NP = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              sys_sel_i = 1'b0, sys_valid_i = 1'b0, sys_write_i = 1'b0;
  logic [AW-1:0]     sys_addr_i = '0;
  logic [DW-1:0]     sys_wdata_i = '0;
  logic              sys_ready_o, per_write_o, per_enable_o;
  logic [DW-1:0]     sys_rdata_o, per_wdata_o;
  logic [AW-1:0]     per_addr_o;
  logic [NP-1:0]     per_sel_o;
  logic [NP*DW-1:0]  per_rdata_i = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit in_reset_check = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pbus_bridge i_pbus_bridge (
    .clk_i, .rst_ni, .sys_sel_i, .sys_valid_i, .sys_addr_i, .sys_write_i,
    .sys_wdata_i, .sys_ready_o, .sys_rdata_o, .per_addr_o, .per_write_o,
    .per_sel_o, .per_enable_o, .per_wdata_o, .per_rdata_i
  );

  // Reference model: 0 idle, 1 setup, 2 enable
  int          m_phase;
  bit          m_b2b;
  logic [15:0] m_addr;
  logic        m_write;
  logic [31:0] m_wd;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_phase = 0; m_b2b = 0; m_addr = '0; m_write = 0; m_wd = '0;
    end else begin
      bit acc;
      acc = sys_sel_i && sys_valid_i && (m_phase != 1);
      if (m_phase == 1 && m_write) m_wd = sys_wdata_i;
      m_b2b = acc && (m_phase == 2);
      if (acc) begin
        m_addr = sys_addr_i; m_write = sys_write_i; m_phase = 1;
      end else if (m_phase == 1) m_phase = 2;
      else m_phase = 0;
    end
  end

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      int idx;
      bit mapped;
      logic [NP-1:0] e_sel;
      logic [31:0] e_rd, e_wd;
      idx    = int'(m_addr[15:12]);
      mapped = idx < NP;
      e_sel  = (m_phase != 0 && mapped) ? NP'(1 << idx) : '0;
      e_wd   = (m_phase == 1 && m_write) ? sys_wdata_i : m_wd;
      e_rd   = (m_phase == 2 && !m_write && mapped) ? per_rdata_i[idx*DW +: DW] : '0;
      if (in_reset_check) begin
        check("R1", "ready", sys_ready_o, 1);
        check("R1", "sel", per_sel_o, 0);
        check("R1", "enable", per_enable_o, 0);
        check("R1", "addr", per_addr_o, 0);
        check("R1", "write", per_write_o, 0);
        check("R1", "wdata", per_wdata_o, 0);
      end
      check(m_phase == 1 ? "R2" : "R10", "ready", sys_ready_o, (m_phase != 1));
      check(m_b2b && m_phase == 1 ? "R8" : "R5", "sel", per_sel_o, e_sel);
      check("R3", "enable", per_enable_o, (m_phase == 2));
      check(m_phase == 0 ? "R9" : "R4", "addr", per_addr_o, m_addr);
      check(m_phase == 0 ? "R9" : "R4", "write", per_write_o, m_write);
      check("R6", "wdata", per_wdata_o, e_wd);
      check("R7", "rdata", sys_rdata_o, e_rd);
    end
  end

  task automatic drive(bit s, bit v, logic [15:0] a, bit w, logic [31:0] d);
    @(negedge clk_i); #1;
    sys_sel_i = s; sys_valid_i = v; sys_addr_i = a; sys_write_i = w; sys_wdata_i = d;
    for (int k = 0; k < NP; k++) per_rdata_i[k*DW +: DW] = $urandom;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    in_reset_check = 1'b1;
    @(negedge clk_i); #1 in_reset_check = 1'b0;
    // Directed: write region 0, then the data phase with wait state
    drive(1, 1, 16'h0010, 1, 32'h0);
    drive(0, 0, 16'h0, 0, 32'hA5A5_0001);
    drive(0, 0, 16'h0, 0, 32'hDEAD_BEEF);
    // R9: qualifiers low one at a time
    drive(1, 0, 16'h1004, 0, 32'h1);
    drive(0, 1, 16'h2008, 0, 32'h2);
    // Read region 2, then back-to-back write region 3 (R8), then unmapped read
    drive(1, 1, 16'h2040, 0, 32'h0);
    drive(0, 0, 16'h0, 0, 32'h0);
    drive(1, 1, 16'h3044, 1, 32'h0);
    drive(0, 0, 16'h0, 0, 32'h1234_5678);
    drive(1, 1, 16'h7000, 0, 32'h0);
    drive(0, 0, 16'h0, 0, 32'h0);
    drive(0, 0, 16'h0, 0, 32'h0);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      a = {4'($urandom_range(0, 5)), 12'($urandom)};
      drive(($urandom % 4) != 0, ($urandom % 4) != 0, a, 1'($urandom), $urandom);
    end
    drive(0, 0, 16'h0, 0, 32'h0);
    repeat (3) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule